// File: doc/BRIEF.md
# Carry-Driven Binary Rate Multiplier

This block turns a stream of input pulses into a thinner stream of output pulses. The thinner stream runs at a programmed fraction of the input rate. An internal register of `WIDTH` bits holds a running phase value. On every clock cycle in which the input pulse enable is high, the programmed rate word is added to that phase. The carry out of the addition is the output pulse. When the rate word is N, exactly N of every 2^WIDTH enabled input pulses produce an output pulse. The phase register then returns to the value it started from.

A rate multiplier built from gated counter stages tends to bunch its missing pulses together. Here the output pulses come from an adder overflow, so they are spread as evenly as the ratio allows. After k enabled steps from a phase of zero, the number of output pulses is floor(k*N / 2^WIDTH). A finer rate step is obtained by raising `WIDTH`. The rate word may change at any time: the next enabled addition uses the new value, and the phase register is not cleared.

Top module: `rate_mult_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase register is loaded with zero. While `rst_n` is low, `pulse_out` is 0.
- R2: On a rising edge with `rst_n` high and `step_en` high, the phase register takes the value (phase + `rate_word`) mod 2^WIDTH.
- R3: `pulse_out` is 1 in exactly those cycles where `step_en` is high and phase + `rate_word` is at least 2^WIDTH. It is asserted in the same cycle as the addition that overflows.
- R4: When `step_en` is low, the phase register holds its value and `pulse_out` is 0.
- R5: Starting from any phase, 2^WIDTH enabled steps with a constant rate word N produce exactly N pulses and leave the phase at its starting value.
- R6: A rate word of 0 produces no pulses and leaves the phase unchanged.
- R7: A new rate word takes effect on the next enabled addition, and the phase register is not cleared.
- R8: With WIDTH = 4 and rate word 11 from phase zero, 16 enabled steps give eleven pulses and end at phase 0000.
- R9: From phase zero with a constant rate word N, the number of pulses after k enabled steps is floor(k*N / 2^WIDTH). This holds for every k from 1 to 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Input pulse: when high, one addition happens this cycle |
| rate_word | input | WIDTH | Programmed rate N, unsigned |
| pulse_out | output | 1 | Output pulse: carry of the enabled addition in this cycle |
| acc_state | output | WIDTH | Current phase register value |

## Verification
A wrong phase value shows at `acc_state` one clock after the faulty addition. From then on it shifts every later carry, so `pulse_out` moves or disappears within the next few enabled steps. A wrong carry shows at `pulse_out` in the same cycle, and the pulse count over a full cycle of 2^WIDTH steps exposes errors that cancel out locally. The cumulative-count check catches pulses that land in the wrong place, not only pulses whose total is wrong.

// File: rtl/rm_pkg.sv
// rm_pkg: shared helpers for the rate multiplier.
// Holds the one-bit full-adder equations used by every adder section.
package rm_pkg;

    // Sum bit of a full adder section.
    function automatic logic fa_sum(input logic a, input logic b, input logic ci);
        return a ^ b ^ ci;
    endfunction

    // Carry bit of a full adder section.
    function automatic logic fa_carry(input logic a, input logic b, input logic ci);
        return (a & b) | (ci & (a ^ b));
    endfunction

endpackage

// File: rtl/rm_adder.sv
// rm_adder: unsigned ripple adder of WIDTH sections with carry out.
// Assumes a zero carry in; purely combinational.
module rm_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    import rm_pkg::*;

    logic [WIDTH:0] chain;

    // Carry into the lowest section is tied to zero.
    assign chain[0] = 1'b0;

    // One full-adder section per bit, carry rippling upward.
    for (genvar i = 0; i < WIDTH; i++) begin : g_sect
        assign sum[i]     = fa_sum(op_a[i], op_b[i], chain[i]);
        assign chain[i+1] = fa_carry(op_a[i], op_b[i], chain[i]);
    end

    assign carry_out = chain[WIDTH];

endmodule

// File: rtl/rm_state_reg.sv
// rm_state_reg: phase register of the rate multiplier.
// Loads next_val when load_en is high, clears on synchronous active-low reset.
module rm_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] next_val,
    output logic [WIDTH-1:0] state
);

    // Phase update: clear, load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= '0;
        else if (load_en) state <= next_val;
    end

    logic past_valid = 1'b0;

    // Marks that at least one edge has been seen, so that $past is meaningful.
    always_ff @(posedge clk) past_valid <= 1'b1;

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(rst_n)) |-> (state == '0));

    a_r2_sum_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && $past(load_en)) |-> (state == $past(next_val)));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && !$past(load_en)) |-> $stable(state));

endmodule

// File: rtl/rate_mult_top.sv
// rate_mult_top: carry-driven binary rate multiplier.
// Adds rate_word to the phase on each enabled cycle; the adder carry is the pulse.
// Assumes step_en is one clock wide per input pulse.
module rate_mult_top #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [WIDTH-1:0] rate_word,
    output logic             pulse_out,
    output logic [WIDTH-1:0] acc_state
);

    logic [WIDTH-1:0] phase_sum;
    logic             phase_carry;

    rm_adder #(.WIDTH(WIDTH)) u_add (
        .op_a      (acc_state),
        .op_b      (rate_word),
        .sum       (phase_sum),
        .carry_out (phase_carry)
    );

    rm_state_reg #(.WIDTH(WIDTH)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (step_en),
        .next_val (phase_sum),
        .state    (acc_state)
    );

    // Output pulse: carry of the addition made this cycle, gated by enable and reset.
    always_comb pulse_out = rst_n & step_en & phase_carry;

    a_r3_pulse_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> step_en);

    a_r3_pulse_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> (acc_state < $past(acc_state)));

    a_r6_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_word == '0) |-> !pulse_out);

endmodule

// File: tb/rate_mult_top_tb.sv
`timescale 1ns/1ps
module rate_mult_top_tb;
    localparam int W = 4;
    localparam int FULL = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         step_en;
    logic [W-1:0] rate_word;
    logic         pulse_out;
    logic [W-1:0] acc_state;

    int n_checks = 0;
    int n_fail = 0;
    logic [W-1:0] m_acc;

    always #2 clk = ~clk;

    rate_mult_top #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .rate_word(rate_word),
        .pulse_out(pulse_out), .acc_state(acc_state)
    );

    function automatic logic exp_carry(input logic [W-1:0] a, input logic [W-1:0] r);
        return ((int'(a) + int'(r)) >= FULL);
    endfunction

    function automatic logic [W-1:0] exp_next(input logic [W-1:0] a, input logic [W-1:0] r);
        return W'((int'(a) + int'(r)) % FULL);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive on negedge, check pulse mid-cycle, check phase after edge.
    task automatic step(input logic en, input logic [W-1:0] r, input string req, output logic p);
        logic ep;
        @(negedge clk);
        step_en = en;
        rate_word = r;
        #1;
        ep = en & exp_carry(m_acc, r);
        p = pulse_out;
        check({req, " pulse"}, int'(pulse_out), int'(ep));
        @(posedge clk);
        if (en) m_acc = exp_next(m_acc, r);
        #1;
        check({req, " phase"}, int'(acc_state), int'(m_acc));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step_en = 1'b1;
        rate_word = 4'd9;
        repeat (2) @(posedge clk);
        #1;
        check("R1 phase cleared", int'(acc_state), 0);
        check("R1 pulse low in reset", int'(pulse_out), 0);
        m_acc = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step_en = 1'b0;
    endtask

    // Full cycle from zero, checking running count (R9) and total/return (R5).
    task automatic full_cycle(input logic [W-1:0] r, input string req);
        int cnt;
        logic p;
        cnt = 0;
        for (int k = 1; k <= FULL; k++) begin
            step(1'b1, r, "R2 R3 cycle", p);
            if (p) cnt++;
            check({req, " R9 running count"}, cnt, (k * int'(r)) / FULL);
        end
        check({req, " R5 total pulses"}, cnt, int'(r));
        check({req, " R5 phase returned"}, int'(acc_state), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic p;
        int cnt;
        rst_n = 1'b0;
        step_en = 1'b0;
        rate_word = '0;
        m_acc = '0;
        do_reset();

        // R8: rate 11 from zero.
        full_cycle(4'd11, "R8");
        // Other rates, including the extremes.
        full_cycle(4'd1, "rate1");
        full_cycle(4'd15, "rate15");
        full_cycle(4'd6, "rate6");

        // R6: a zero rate gives no pulses and the phase is left unchanged.
        step(1'b1, 4'd5, "R2 pre", p);
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 4'd0, "R6 zero rate", p);
            if (p) cnt++;
        end
        check("R6 no pulses", cnt, 0);
        check("R6 phase unchanged", int'(acc_state), 5);

        // R4: enable low holds the phase even with a rate that would overflow.
        step(1'b1, 4'd10, "R2 pre", p);
        for (int k = 0; k < 4; k++) step(1'b0, 4'd15, "R4 idle", p);
        check("R4 phase held", int'(acc_state), 15);

        // R7: a new rate is used on the next addition and the phase is not cleared.
        step(1'b1, 4'd3, "R7 new rate", p);
        check("R7 phase continued", int'(acc_state), 2);
        check("R7 carry with new rate", int'(p), 1);

        // R5 from a nonzero start phase.
        cnt = 0;
        for (int k = 0; k < FULL; k++) begin
            step(1'b1, 4'd7, "R5 offset", p);
            if (p) cnt++;
        end
        check("R5 offset total", cnt, 7);
        check("R5 offset phase", int'(acc_state), 2);

        // Random enables and rates from a fixed seed.
        void'($urandom(32'd2024));
        for (int k = 0; k < 3000; k++) begin
            logic en;
            logic [W-1:0] r;
            en = ($urandom % 4) != 0;
            r = W'($urandom);
            if (k % 50 == 49) begin
                do_reset();
            end else begin
                step(en, r, "R2 R3 R4 R7 random", p);
            end
        end

        // Reset mid-run clears the phase (R1).
        step(1'b1, 4'd9, "R2 pre", p);
        do_reset();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule